// File: doc/BRIEF.md
# SPI Command Responder Slave

This block is an SPI slave that carries a small opcode protocol. Inside each chip-select window, the master first sends a one-byte opcode. Three opcodes ask the slave to stream a fixed constant answer back. Three other opcodes announce a payload of fixed length, which the slave collects and then writes into one of three output register banks. Any other opcode is ignored.

The serial clock, the serial input and the active-low select are sampled by the single system clock. The system clock must run at least four times faster than the serial clock. The bus uses clock polarity high with mode-3 phasing:

- The slave drives its output bit after each falling serial-clock edge.
- It captures the input bit on each rising edge.

When an answer opcode is decoded, the first answer byte is loaded at once. The master reads it in the frame that follows the opcode. A rising select aborts whatever was in progress.

Top module: `spi_cmd_responder`

## Requirements
- R1: The serial clock idles high. Frames are 8 bits, most significant bit first. The input bit is taken on the rising serial-clock edge. `miso` changes only after a falling edge and holds its value through the following rising edge.
- R2: Serial-clock edges seen while `cs_n` is high have no effect. No bits are counted, no state changes and no bank is written, so the next framed transaction works normally.
- R3: Opcodes 0x00, 0x01 and 0x02 are answer opcodes. The answer appears in the frames right after the opcode frame:
  - 0x00 answers 0x11.
  - 0x01 answers 0x15, then 0x16.
  - 0x02 answers 0x41, 0x42, 0x43, 0x44, 0x31, 0x32.
- R4: `miso` shifts out 0xFF in every frame that has no answer byte pending. This covers the opcode frame itself and the frames after an answer has been fully sent.
- R5: Opcodes 0x03, 0x04 and 0x05 announce payloads of 1, 2 and 6 bytes, which are written to `bank0`, `bank1` and `bank2`. Payload byte k lands in bits [8k+7:8k], so the first byte is the least significant.
- R6: `done` pulses for exactly one system clock in two cases. For a payload, it pulses when the payload is committed. For an answer, it pulses when the last answer byte is loaded; for 0x00 this is at the end of the first frame after the opcode. A bank never changes without `done`.
- R7: An opcode outside 0x00..0x05 causes no action. The next byte in the same select window is decoded as a fresh opcode.
- R8: A rising edge on `cs_n` returns the block to opcode decoding. A partly received payload is discarded without touching any bank or `done`, and a partly sent answer is dropped, so the next frame shifts 0xFF.
- R9: If a frame's last rising serial-clock edge and the rising edge of `cs_n` reach the block in the same cycle, that byte is discarded. There is no commit and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the master |
| bank0 | output | 8 | Register bank written by opcode 0x03 |
| bank1 | output | 16 | Register bank written by opcode 0x04 |
| bank2 | output | 48 | Register bank written by opcode 0x05 |
| done | output | 1 | One-cycle transaction completion strobe |

## Verification
Byte completion and the chip-select abort can fall in the same system-clock cycle. This happens when the eighth rising serial-clock edge of a payload frame and the release of `cs_n` pass through the synchronizers together. The bench provokes it by raising `sclk` and `cs_n` in the same instant on the final bit of a one-byte payload. It judges the outcome by requiring that `bank0` keeps its old value and that no `done` pulse is counted. It then proves that the slave is back at opcode decoding by running a normal payload transaction straight afterwards.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;

  localparam int BYTE_W  = 8;
  localparam int MAX_LEN = 6;
  localparam int IDX_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_TX  = 2'd1,
    ST_RX  = 2'd2
  } mode_e;

  // Transfer length for a 2-bit opcode group selector (shared by answers and payloads)
  function automatic logic [IDX_W-1:0] op_len(input logic [1:0] sel);
    case (sel)
      2'd0:    op_len = IDX_W'(1);
      2'd1:    op_len = IDX_W'(2);
      default: op_len = IDX_W'(MAX_LEN);
    endcase
  endfunction

  // Constant answer byte idx of answer group sel
  function automatic logic [BYTE_W-1:0] resp_byte(input logic [1:0] sel,
                                                   input logic [IDX_W-1:0] idx);
    resp_byte = 8'hFF;
    case (sel)
      2'd0: resp_byte = 8'h11;
      2'd1: resp_byte = (idx == '0) ? 8'h15 : 8'h16;
      default: begin
        case (idx)
          IDX_W'(0): resp_byte = 8'h41;
          IDX_W'(1): resp_byte = 8'h42;
          IDX_W'(2): resp_byte = 8'h43;
          IDX_W'(3): resp_byte = 8'h44;
          IDX_W'(4): resp_byte = 8'h31;
          default:   resp_byte = 8'h32;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else if (g == 0) stage_q[g] <= pins_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_hi,
  input  logic              cs_rise,
  input  logic              mosi_s,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              miso_o
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              miso_q, miso_d;
  logic              take_bit, put_bit;

  assign take_bit = sclk_rise & ~cs_hi;
  assign put_bit  = sclk_fall & ~cs_hi;

  assign byte_valid_o = take_bit & (bit_q == CNT_W'(BYTE_W-1));
  assign rx_byte_o    = {rx_q[BYTE_W-2:0], mosi_s};
  assign miso_o       = miso_q;

  always_comb begin
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    if (cs_hi) begin
      bit_d = '0;
    end else if (take_bit) begin
      rx_d  = {rx_q[BYTE_W-2:0], mosi_s};
      bit_d = bit_q + CNT_W'(1);
    end
    if (cs_rise) begin
      tx_d   = '1;
      miso_d = 1'b1;
    end else if (load_i) begin
      tx_d = load_byte_i;
    end else if (put_bit) begin
      miso_d = tx_q[BYTE_W-1];
      tx_d   = {tx_q[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '1;
      miso_q <= 1'b1;
    end else begin
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_resp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      abort_i,
  input  logic                      byte_valid_i,
  input  logic [BYTE_W-1:0]         rx_byte_i,
  output logic                      tx_load_o,
  output logic [BYTE_W-1:0]         tx_byte_o,
  output logic [BYTE_W-1:0]         bank0_o,
  output logic [2*BYTE_W-1:0]       bank1_o,
  output logic [MAX_LEN*BYTE_W-1:0] bank2_o,
  output logic                      done_o,
  output mode_e                     mode_o
);

  mode_e                     mode_q, mode_d;
  logic [1:0]                sel_q, sel_d;
  logic [IDX_W-1:0]          cnt_q, cnt_d, len;
  logic [BYTE_W-1:0]         buf_q [MAX_LEN];
  logic [BYTE_W-1:0]         buf_d [MAX_LEN];
  logic [BYTE_W-1:0]         merged [MAX_LEN];
  logic [BYTE_W-1:0]         bank0_q, bank0_d;
  logic [2*BYTE_W-1:0]       bank1_q, bank1_d;
  logic [MAX_LEN*BYTE_W-1:0] bank2_q, bank2_d;
  logic                      done_q, done_d;

  assign len = op_len(sel_q);

  always_comb begin
    merged = buf_q;
    if (cnt_q < IDX_W'(MAX_LEN)) merged[cnt_q] = rx_byte_i;
  end

  always_comb begin
    mode_d    = mode_q;
    sel_d     = sel_q;
    cnt_d     = cnt_q;
    buf_d     = buf_q;
    bank0_d   = bank0_q;
    bank1_d   = bank1_q;
    bank2_d   = bank2_q;
    done_d    = 1'b0;
    tx_load_o = 1'b0;
    tx_byte_o = '1;
    if (abort_i) begin
      mode_d = ST_CMD;
      cnt_d  = '0;
    end else if (byte_valid_i) begin
      case (mode_q)
        ST_CMD: begin
          if (rx_byte_i < 8'd3) begin
            mode_d    = ST_TX;
            sel_d     = rx_byte_i[1:0];
            cnt_d     = IDX_W'(1);
            tx_load_o = 1'b1;
            tx_byte_o = resp_byte(rx_byte_i[1:0], '0);
          end else if (rx_byte_i < 8'd6) begin
            mode_d = ST_RX;
            sel_d  = 2'(rx_byte_i - 8'd3);
            cnt_d  = '0;
          end
        end
        ST_TX: begin
          if (cnt_q < len) begin
            tx_load_o = 1'b1;
            tx_byte_o = resp_byte(sel_q, cnt_q);
            cnt_d     = cnt_q + IDX_W'(1);
          end
          if (cnt_d >= len) begin
            done_d = 1'b1;
            mode_d = ST_CMD;
            cnt_d  = '0;
          end
        end
        ST_RX: begin
          buf_d = merged;
          if (cnt_q + IDX_W'(1) == len) begin
            case (sel_q)
              2'd0:    bank0_d = merged[0];
              2'd1:    bank1_d = {merged[1], merged[0]};
              default: for (int k = 0; k < MAX_LEN; k++) bank2_d[k*BYTE_W +: BYTE_W] = merged[k];
            endcase
            done_d = 1'b1;
            mode_d = ST_CMD;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + IDX_W'(1);
          end
        end
        default: mode_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ST_CMD;
      sel_q   <= '0;
      cnt_q   <= '0;
      bank0_q <= '0;
      bank1_q <= '0;
      bank2_q <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < MAX_LEN; k++) buf_q[k] <= '0;
    end else begin
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
      bank0_q <= bank0_d;
      bank1_q <= bank1_d;
      bank2_q <= bank2_d;
      done_q  <= done_d;
      buf_q   <= buf_d;
    end
  end

  assign bank0_o = bank0_q;
  assign bank1_o = bank1_q;
  assign bank2_o = bank2_q;
  assign done_o  = done_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/spi_cmd_responder.sv
module spi_cmd_responder
  import spi_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic        cs_n,
  output logic        miso,
  output logic [7:0]  bank0,
  output logic [15:0] bank1,
  output logic [47:0] bank2,
  output logic        done
);

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic [2:0]        pin_sync, pin_rise, pin_fall;
  logic              cs_s, cs_rise, sclk_rise, sclk_fall, mosi_s;
  logic              byte_valid, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  mode_e             eng_mode;

  // Reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  // Bit order: [2]=cs_n, [1]=mosi, [0]=sclk
  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b111)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .pins_i({cs_n, mosi, sclk}),
    .sync_o(pin_sync),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign cs_s      = pin_sync[2];
  assign cs_rise   = pin_rise[2];
  assign mosi_s    = pin_sync[1];
  assign sclk_rise = pin_rise[0];
  assign sclk_fall = pin_fall[0];

  spi_byte_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .cs_hi       (cs_s),
    .cs_rise     (cs_rise),
    .mosi_s      (mosi_s),
    .load_i      (tx_load),
    .load_byte_i (tx_byte),
    .byte_valid_o(byte_valid),
    .rx_byte_o   (rx_byte),
    .miso_o      (miso)
  );

  spi_cmd_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .abort_i     (cs_rise),
    .byte_valid_i(byte_valid),
    .rx_byte_i   (rx_byte),
    .tx_load_o   (tx_load),
    .tx_byte_o   (tx_byte),
    .bank0_o     (bank0),
    .bank1_o     (bank1),
    .bank2_o     (bank2),
    .done_o      (done),
    .mode_o      (eng_mode)
  );

endmodule

// File: rtl/spi_cmd_responder_chk.sv
module spi_cmd_responder_chk
  import spi_resp_pkg::*;
(
  input logic        clk,
  input logic        rst_s_n,
  input logic        cs_s,
  input logic        cs_rise,
  input logic        byte_valid,
  input logic        done,
  input logic        miso,
  input logic [7:0]  bank0,
  input logic [15:0] bank1,
  input logic [47:0] bank2,
  input logic [1:0]  eng_mode
);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);  // R6

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> $past(byte_valid));  // R6

  AST_BANK_WRITE_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!$stable(bank0) || !$stable(bank1) || !$stable(bank2)) |-> done);  // R5

  AST_CS_HIGH_FREEZES_BANKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_s |=> ($stable(bank0) && $stable(bank1) && $stable(bank2) && !done));  // R2

  AST_ABORT_TO_OPCODE: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_rise |=> (eng_mode == 2'(ST_CMD)));  // R8

  AST_ABORT_MISO_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_rise |=> miso);  // R4

endmodule

bind spi_cmd_responder spi_cmd_responder_chk i_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .cs_s      (cs_s),
  .cs_rise   (cs_rise),
  .byte_valid(byte_valid),
  .done      (done),
  .miso      (miso),
  .bank0     (bank0),
  .bank1     (bank1),
  .bank2     (bank2),
  .eng_mode  (eng_mode)
);

// File: tb/test_spi_cmd_responder.sv
module test_spi_cmd_responder;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, mosi, cs_n;
  logic        miso;
  logic [7:0]  bank0;
  logic [15:0] bank1;
  logic [47:0] bank2;
  logic        done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int exp_done = 0;
  bit hold = 1'b1;
  logic [7:0]  m_b0 = '0;
  logic [15:0] m_b1 = '0;
  logic [47:0] m_b2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_responder i_spi_cmd_responder (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .bank0(bank0), .bank1(bank1), .bank2(bank2), .done(done)
  );

  // Per-clock comparison against the behavioural bank model
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (!hold) begin
        checks++;
        if (bank0 !== m_b0 || bank1 !== m_b1 || bank2 !== m_b2) begin
          errors++;
          $display("FAIL R5 per-cycle banks: act %h/%h/%h exp %h/%h/%h",
                   bank0, bank1, bank2, m_b0, m_b1, m_b2);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] answer(input int op, input int i);
    string s;
    s = "ABCD12";
    if (op == 0) return 8'h11;
    if (op == 1) return (i == 0) ? 8'h15 : 8'h16;
    return 8'(s[i]);
  endfunction

  // One frame: drive mode-3 bits, capture miso before each rising edge
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit cs_last);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      if (b == 0 && cs_last) cs_n = 1'b1;
      repeat (HP - 1) @(negedge clk);
      chk("R1 miso held over rising edge", 64'(miso), 64'(rx[b]));
    end
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk); cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic run_answer(input int op, input int len);
    logic [7:0] r;
    sel_on();
    xfer(8'(op), r, 1'b0);
    chk("R4 opcode frame shifts FF", 64'(r), 64'hFF);
    for (int i = 0; i < len; i++) begin
      xfer(8'hFF, r, 1'b0);
      chk($sformatf("R3 op%0d byte%0d", op, i), 64'(r), 64'(answer(op, i)));
      if (op == 1) chk("R1 msb-first order", 64'(r[7:4]), 64'(1));
    end
    xfer(8'hFF, r, 1'b0);
    chk("R4 frame after answer shifts FF", 64'(r), 64'hFF);
    sel_off();
    exp_done++;
    chk("R6 answer done pulse count", 64'(done_cnt), 64'(exp_done));
  endtask

  task automatic run_payload(input int op, input logic [47:0] data, input int len);
    logic [7:0] r;
    sel_on();
    xfer(8'(op), r, 1'b0);
    chk("R4 FF during payload opcode", 64'(r), 64'hFF);
    hold = 1'b1;
    for (int i = 0; i < len; i++) xfer(data[i*8 +: 8], r, 1'b0);
    sel_off();
    if (op == 3) m_b0 = data[7:0];
    else if (op == 4) m_b1 = data[15:0];
    else m_b2 = data;
    hold = 1'b0;
    exp_done++;
    chk("R5 bank0", 64'(bank0), 64'(m_b0));
    chk("R5 bank1", 64'(bank1), 64'(m_b1));
    chk("R5 bank2", 64'(bank2), 64'(m_b2));
    chk("R6 payload done pulse count", 64'(done_cnt), 64'(exp_done));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; sclk = 1'b1; mosi = 1'b0; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 reset miso", 64'(miso), 64'(1));
    chk("R6 reset done", 64'(done), 64'(0));
    hold = 1'b0;

    run_answer(0, 1);
    run_answer(1, 2);
    run_answer(2, 6);

    run_payload(3, 48'hA5, 1);
    run_payload(4, 48'h3412, 2);
    run_payload(5, 48'h665544332211, 6);

    // R7: unknown opcode then a real one in the same window
    sel_on();
    xfer(8'h7E, r, 1'b0);
    chk("R7 unknown opcode frame FF", 64'(r), 64'hFF);
    xfer(8'h00, r, 1'b0);
    chk("R7 no answer after unknown opcode", 64'(r), 64'hFF);
    xfer(8'hFF, r, 1'b0);
    chk("R7 next opcode decoded", 64'(r), 64'h11);
    sel_off();
    exp_done++;
    chk("R7 done count", 64'(done_cnt), 64'(exp_done));

    // R2: clock an opcode and 3 stray bits with select high
    for (int b = 10; b >= 0; b--) begin
      @(negedge clk); sclk = 1'b0; mosi = (b < 8) ? 1'b0 : 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk);
    end
    chk("R2 no done while deselected", 64'(done_cnt), 64'(exp_done));
    sel_on();
    xfer(8'hFF, r, 1'b0);
    chk("R2 ignored opcode gave no answer", 64'(r), 64'hFF);
    xfer(8'h00, r, 1'b0);
    xfer(8'hFF, r, 1'b0);
    chk("R2 framing intact afterwards", 64'(r), 64'h11);
    sel_off();
    exp_done++;

    // R8: abort a 6-byte payload halfway
    sel_on();
    xfer(8'h05, r, 1'b0);
    for (int i = 0; i < 3; i++) xfer(8'hEE, r, 1'b0);
    sel_off();
    chk("R8 aborted payload bank2", 64'(bank2), 64'(m_b2));
    chk("R8 aborted payload no done", 64'(done_cnt), 64'(exp_done));
    run_payload(3, 48'h5A, 1);

    // R8: abort an answer stream
    sel_on();
    xfer(8'h02, r, 1'b0);
    xfer(8'hFF, r, 1'b0);
    sel_off();
    sel_on();
    xfer(8'hFF, r, 1'b0);
    chk("R8 dropped answer shifts FF", 64'(r), 64'hFF);
    sel_off();

    // R9: last rising edge coincides with select release
    sel_on();
    xfer(8'h03, r, 1'b0);
    hold = 1'b1;
    xfer(8'hC3, r, 1'b1);
    repeat (12) @(negedge clk);
    hold = 1'b0;
    chk("R9 coincident byte not committed", 64'(bank0), 64'(m_b0));
    chk("R9 coincident byte no done", 64'(done_cnt), 64'(exp_done));
    run_payload(3, 48'h3C, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule